// File: doc/BRIEF.md
# Interrupt and Reset Input Conditioner

This block sits between the asynchronous control pins of a small processor core and the core's sequencer. It brings four raw inputs into the clock domain through multi-stage synchronisers: a level-sensitive maskable interrupt request, an edge-sensitive non-maskable request, a TEST line consulted by the wait instruction, and an external reset request. From these it derives the few conditioned signals the sequencer needs.

A rising edge on the non-maskable line sets a pending flag. The flag stays set until the core acknowledges it. The maskable line is never latched: its synchronised level is examined only when the core pulses its instruction-boundary strobe, and only while the core's interrupt-enable flag is set. At each boundary the block issues a one-cycle decision. The non-maskable (type 2) interrupt wins over the maskable one.

The external reset is passed on only after it has been seen on a minimum number of consecutive clocks. A shorter glitch leaves the core untouched. While the conditioned reset is active, the pending flag is wiped and no interrupt is issued. The block also forms the wait-idle condition from the core's wait state and the synchronised TEST level.

Top module: `irq_rst_conditioner`

## Requirements
- R1: With the non-maskable flag clear, a strobe on `instrEnd` while the synchronised maskable level and `intEnable` are both 1 makes `takeMask` 1 for exactly the cycle after the strobe edge. In that same cycle `takeNmi` is 0.
- R2: When `intEnable` is 0 at the strobe edge, `takeMask` stays 0 whatever the maskable level.
- R3: The maskable request is not latched. A level that is high only while `instrEnd` is 0, and that has fallen (through the synchroniser) before the strobe, produces no `takeMask`.
- R4: A 0-to-1 change on `nmiIn` that is first sampled at clock edge k makes `nmiPending` 1 after edge k+2.
- R5: At a strobe with `nmiPending` set, `takeNmi` is 1 for the cycle after the strobe edge. `takeMask` is 0 in that cycle, whatever the values of `intEnable` and the maskable level.
- R6: `nmiPending` is cleared by a one-cycle `nmiAck` and stays cleared while `nmiIn` is held high. Only a new low-to-high transition sets it again.
- R7: `waitIdle` equals `waitActive` AND the TEST level delayed by two clock edges of synchronisation, and is forced to 0 during conditioned reset.
- R8: `coreReset` rises after edge k+5 when `rstIn` is sampled high on four consecutive edges starting at edge k (HOLD_CYCLES = 4). It falls after the third edge after `rstIn` is first sampled low.
- R9: A `rstIn` pulse seen on fewer than four consecutive edges never raises `coreReset` and leaves `nmiPending` unchanged.
- R10: While `coreReset` is 1, `nmiPending` is cleared and neither `takeNmi` nor `takeMask` is issued.
- R11: While `arstN` is 0 and after its release with all inputs low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| arstN | input | 1 | Asynchronous power-on clear of the block, active low |
| rstIn | input | 1 | Raw external reset request, active high, asynchronous |
| maskIn | input | 1 | Raw maskable interrupt request, active-high level |
| nmiIn | input | 1 | Raw non-maskable request, rising edge significant |
| testIn | input | 1 | Raw TEST line; high keeps a wait instruction idle |
| intEnable | input | 1 | Core interrupt-enable flag, synchronous |
| instrEnd | input | 1 | One-cycle strobe in the last clock of an instruction |
| waitActive | input | 1 | Core is executing a wait instruction |
| nmiAck | input | 1 | One-cycle acknowledge clearing the pending non-maskable flag |
| nmiPending | output | 1 | Latched non-maskable request |
| takeNmi | output | 1 | One-cycle decision: take the type 2 interrupt |
| takeMask | output | 1 | One-cycle decision: take the maskable interrupt |
| coreReset | output | 1 | Qualified reset to the core, active high |
| waitIdle | output | 1 | Core must stay idle in its wait instruction |

## Verification
A wrong pending flag shows at `nmiPending` on the very next cycle. It also shows as a misdirected `takeNmi` or `takeMask` one cycle after the next boundary strobe. A hold counter that is off by one moves the `coreReset` rising edge by a cycle, or lets a three-sample glitch through. Because of this, the edge cycle itself is sampled for every pulse length from one to six. Synchroniser depth errors shift the pending and wait-idle responses by whole cycles, so those are checked on the exact edge rather than eventually.

// File: rtl/icond_pkg.sv
package icond_pkg;

  // Conditioned view of the inputs, produced by the datapath
  typedef struct packed {
    logic rstLvl;
    logic maskLvl;
    logic testLvl;
    logic nmiRise;
    logic nmiPend;
    logic holdDone;
    logic coreRst;
  } condStat_t;

  // Strobes from the control to the datapath registers
  typedef struct packed {
    logic setNmi;
    logic clrNmi;
    logic cntInc;
    logic cntClr;
    logic rstOn;
    logic rstOff;
    logic issueNmi;
    logic issueMask;
  } ctlStrobe_t;

  localparam int SIG_RST  = 0;
  localparam int SIG_MASK = 1;
  localparam int SIG_NMI  = 2;
  localparam int SIG_TEST = 3;
  localparam int SIG_COUNT = 4;

endpackage

// File: rtl/icSync.sv
module icSync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) chain[s] <= '0;
        else        chain[s] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge arstN) begin
        if (!arstN) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/icCondPath.sv
module icCondPath
  import icond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       rstIn,
  input  logic       maskIn,
  input  logic       nmiIn,
  input  logic       testIn,
  input  ctlStrobe_t strb,
  output condStat_t  stat,
  output logic       nmiPending,
  output logic       takeNmi,
  output logic       takeMask,
  output logic       coreReset
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [SIG_COUNT-1:0] rawV;
  logic [SIG_COUNT-1:0] syncV;
  logic                 nmiPrev;
  logic [CNT_W-1:0]     holdCnt;
  logic                 coreRstQ;
  logic                 nmiPendQ;
  logic                 takeNmiQ;
  logic                 takeMaskQ;

  always_comb begin
    rawV           = '0;
    rawV[SIG_RST]  = rstIn;
    rawV[SIG_MASK] = maskIn;
    rawV[SIG_NMI]  = nmiIn;
    rawV[SIG_TEST] = testIn;
  end

  icSync #(
    .WIDTH  (SIG_COUNT),
    .STAGES (SYNC_STAGES)
  ) uSync (
    .clk     (clk),
    .arstN   (arstN),
    .asyncIn (rawV),
    .syncOut (syncV)
  );

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      nmiPrev   <= 1'b0;
      holdCnt   <= '0;
      coreRstQ  <= 1'b0;
      nmiPendQ  <= 1'b0;
      takeNmiQ  <= 1'b0;
      takeMaskQ <= 1'b0;
    end else begin
      nmiPrev <= syncV[SIG_NMI];
      if (strb.cntClr)      holdCnt <= '0;
      else if (strb.cntInc) holdCnt <= holdCnt + CNT_W'(1);
      if (strb.rstOn)       coreRstQ <= 1'b1;
      else if (strb.rstOff) coreRstQ <= 1'b0;
      if (strb.setNmi)      nmiPendQ <= 1'b1;
      else if (strb.clrNmi) nmiPendQ <= 1'b0;
      takeNmiQ  <= strb.issueNmi;
      takeMaskQ <= strb.issueMask;
    end
  end

  always_comb begin
    stat.rstLvl   = syncV[SIG_RST];
    stat.maskLvl  = syncV[SIG_MASK];
    stat.testLvl  = syncV[SIG_TEST];
    stat.nmiRise  = syncV[SIG_NMI] & ~nmiPrev;
    stat.nmiPend  = nmiPendQ;
    stat.holdDone = (holdCnt == HOLD_LAST);
    stat.coreRst  = coreRstQ;
  end

  assign nmiPending = nmiPendQ;
  assign takeNmi    = takeNmiQ;
  assign takeMask   = takeMaskQ;
  assign coreReset  = coreRstQ;

  AST_PEND_KEEP: assert property (@(posedge clk) disable iff (!arstN)
    (nmiPendQ && !strb.clrNmi) |=> nmiPendQ);  // R6
  AST_NMI_FROM_PEND: assert property (@(posedge clk) disable iff (!arstN)
    takeNmiQ |-> $past(nmiPendQ));  // R5
  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (!arstN)
    $onehot0({strb.issueNmi, strb.issueMask}));  // R5
  AST_RST_AFTER_HOLD: assert property (@(posedge clk) disable iff (!arstN)
    $rose(coreRstQ) |-> ($past(holdCnt) == HOLD_LAST));  // R8
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!arstN)
    !syncV[SIG_RST] |=> !coreRstQ);  // R8
  AST_RST_WIPES_PEND: assert property (@(posedge clk) disable iff (!arstN)
    (coreRstQ && $past(coreRstQ)) |-> (!nmiPendQ && !takeNmiQ && !takeMaskQ));  // R10

endmodule

// File: rtl/icCondCtl.sv
module icCondCtl
  import icond_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  condStat_t  stat,
  input  logic       intEnable,
  input  logic       instrEnd,
  input  logic       waitActive,
  input  logic       nmiAck,
  output ctlStrobe_t strb,
  output logic       waitIdle
);

  logic boundaryOk;

  assign boundaryOk = instrEnd & ~stat.coreRst;

  always_comb begin
    // Pending non-maskable flag: a fresh edge beats an acknowledge, reset beats both
    strb.setNmi    = stat.nmiRise & ~stat.coreRst;
    strb.clrNmi    = stat.coreRst | (nmiAck & ~stat.nmiRise);
    // Reset qualification: count consecutive high samples, saturate at the limit
    strb.cntInc    = stat.rstLvl & ~stat.holdDone;
    strb.cntClr    = ~stat.rstLvl;
    strb.rstOn     = stat.rstLvl & stat.holdDone;
    strb.rstOff    = ~stat.rstLvl;
    // Boundary decision: non-maskable first, maskable only when enabled
    strb.issueNmi  = boundaryOk & stat.nmiPend;
    strb.issueMask = boundaryOk & ~stat.nmiPend & stat.maskLvl & intEnable;
  end

  assign waitIdle = waitActive & stat.testLvl & ~stat.coreRst;

  AST_NO_STROBE_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!arstN)
    !instrEnd |-> (!strb.issueNmi && !strb.issueMask));  // R3

endmodule

// File: rtl/irq_rst_conditioner.sv
module irq_rst_conditioner
  import icond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic arstN,
  input  logic rstIn,
  input  logic maskIn,
  input  logic nmiIn,
  input  logic testIn,
  input  logic intEnable,
  input  logic instrEnd,
  input  logic waitActive,
  input  logic nmiAck,
  output logic nmiPending,
  output logic takeNmi,
  output logic takeMask,
  output logic coreReset,
  output logic waitIdle
);

  condStat_t  stat;
  ctlStrobe_t strb;

  icCondPath #(
    .SYNC_STAGES (SYNC_STAGES),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) uPath (
    .clk        (clk),
    .arstN      (arstN),
    .rstIn      (rstIn),
    .maskIn     (maskIn),
    .nmiIn      (nmiIn),
    .testIn     (testIn),
    .strb       (strb),
    .stat       (stat),
    .nmiPending (nmiPending),
    .takeNmi    (takeNmi),
    .takeMask   (takeMask),
    .coreReset  (coreReset)
  );

  icCondCtl uCtl (
    .clk        (clk),
    .arstN      (arstN),
    .stat       (stat),
    .intEnable  (intEnable),
    .instrEnd   (instrEnd),
    .waitActive (waitActive),
    .nmiAck     (nmiAck),
    .strb       (strb),
    .waitIdle   (waitIdle)
  );

  AST_MASK_GATED: assert property (@(posedge clk) disable iff (!arstN)
    takeMask |-> $past(intEnable && instrEnd));  // R2

endmodule

// File: tb/irq_rst_conditioner_test.sv
module irq_rst_conditioner_test;

  logic clk = 1'b0;
  logic arstN, rstIn, maskIn, nmiIn, testIn;
  logic intEnable, instrEnd, waitActive, nmiAck;
  logic nmiPending, takeNmi, takeMask, coreReset, waitIdle;

  int nVec = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  irq_rst_conditioner uut (
    .clk(clk), .arstN(arstN), .rstIn(rstIn), .maskIn(maskIn), .nmiIn(nmiIn),
    .testIn(testIn), .intEnable(intEnable), .instrEnd(instrEnd),
    .waitActive(waitActive), .nmiAck(nmiAck), .nmiPending(nmiPending),
    .takeNmi(takeNmi), .takeMask(takeMask), .coreReset(coreReset),
    .waitIdle(waitIdle)
  );

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic strobe;
    instrEnd = 1'b1;
    step();
    instrEnd = 1'b0;
  endtask

  task automatic ackPulse;
    nmiAck = 1'b1;
    step();
    nmiAck = 1'b0;
  endtask

  task automatic makeEdge;
    nmiIn = 1'b0;
    step(3);
    nmiIn = 1'b1;
    step(3);
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    arstN = 1'b0; rstIn = 1'b0; maskIn = 1'b0; nmiIn = 1'b0; testIn = 1'b0;
    intEnable = 1'b0; instrEnd = 1'b0; waitActive = 1'b0; nmiAck = 1'b0;
    step(2);
    chk("R11 takeNmi in clear", takeNmi, 1'b0);
    arstN = 1'b1;
    step(3);
    chk("R11 nmiPending", nmiPending, 1'b0);
    chk("R11 takeMask", takeMask, 1'b0);
    chk("R11 coreReset", coreReset, 1'b0);
    chk("R11 waitIdle", waitIdle, 1'b0);

    // R1 R2 R5: sweep pending x maskable level x enable
    for (int c = 0; c < 8; c++) begin
      logic p, m, e;
      p = c[2]; m = c[1]; e = c[0];
      if (p) makeEdge();
      maskIn = m; intEnable = e;
      step(3);
      strobe();
      chk($sformatf("R5 takeNmi p%0b m%0b e%0b", p, m, e), takeNmi, p);
      chk($sformatf("R1 R2 takeMask p%0b m%0b e%0b", p, m, e), takeMask, !p && m && e);
      step();
      chk("R1 takeMask one cycle", takeMask, 1'b0);
      ackPulse();
      maskIn = 1'b0; nmiIn = 1'b0; intEnable = 1'b0;
      step(3);
    end

    // R3: level not latched
    intEnable = 1'b1; maskIn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R3 no take without strobe", takeMask, 1'b0);
    end
    maskIn = 1'b0;
    step(3);
    strobe();
    chk("R3 dropped level not taken", takeMask, 1'b0);
    intEnable = 1'b0;

    // R4: pending timing
    nmiIn = 1'b1;
    step(2);
    chk("R4 pending not yet", nmiPending, 1'b0);
    step();
    chk("R4 pending on edge k+2", nmiPending, 1'b1);

    // R6: ack and re-arm
    ackPulse();
    chk("R6 cleared by ack", nmiPending, 1'b0);
    step(5);
    chk("R6 held level does not re-set", nmiPending, 1'b0);
    nmiIn = 1'b0;
    step(3);
    nmiIn = 1'b1;
    step(3);
    chk("R6 new edge sets again", nmiPending, 1'b1);
    ackPulse();
    nmiIn = 1'b0;
    step(3);

    // R7: wait idle
    waitActive = 1'b1; testIn = 1'b1;
    step();
    chk("R7 test lag", waitIdle, 1'b0);
    step();
    chk("R7 idle after sync", waitIdle, 1'b1);
    testIn = 1'b0;
    step();
    chk("R7 still idle", waitIdle, 1'b1);
    step();
    chk("R7 resume", waitIdle, 1'b0);
    testIn = 1'b1;
    step(2);
    waitActive = 1'b0;
    #1;
    chk("R7 no wait instr", waitIdle, 1'b0);
    testIn = 1'b0;
    step(2);

    // R8 R9 R10: reset pulse length sweep
    for (int len = 1; len <= 6; len++) begin
      logic saw;
      saw = 1'b0;
      makeEdge();
      for (int i = 0; i < len + 8; i++) begin
        rstIn = (i < len);
        step();
        if (coreReset) saw = 1'b1;
        if (len >= 4 && i == 4) chk($sformatf("R8 not early len%0d", len), coreReset, 1'b0);
        if (len >= 4 && i == 5) chk($sformatf("R8 rises len%0d", len), coreReset, 1'b1);
        if (len >= 4 && i == len + 1) chk($sformatf("R8 still high len%0d", len), coreReset, 1'b1);
        if (len >= 4 && i == len + 2) chk($sformatf("R8 released len%0d", len), coreReset, 1'b0);
      end
      chk($sformatf("R9 R8 any reset len%0d", len), saw, len >= 4);
      chk($sformatf("R9 R10 pending len%0d", len), nmiPending, len < 4);
      ackPulse();
      nmiIn = 1'b0;
      step(3);
    end

    // R10: no decisions while in reset
    rstIn = 1'b1; maskIn = 1'b1; intEnable = 1'b1;
    step(7);
    chk("R10 reset active", coreReset, 1'b1);
    nmiIn = 1'b1;
    step(3);
    chk("R10 edge ignored in reset", nmiPending, 1'b0);
    strobe();
    chk("R10 no maskable take", takeMask, 1'b0);
    chk("R10 no nmi take", takeNmi, 1'b0);
    rstIn = 1'b0;
    step(4);
    strobe();
    chk("R1 after reset release", takeMask, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule